// File: doc/BRIEF.md
# Relooping Instruction Queue with Kill

This block is the instruction front end of a data-moving dock. It holds incoming 37-bit micro-instruction words in a small circular queue and moves them, one at a time, into a single on-deck register. There it decides whether each word executes, is discarded, or is copied back into the queue so that it runs again. A two-bit grouping field in each word drives these decisions. Words marked solo run once. Words marked body or tail form a multi-word group that repeats for as long as an external loop counter is nonzero.

A separate kill instruction does not travel down the instruction path. Once accepted, it parks in a one-entry hold register. When the on-deck word is one of the killable kinds, the kill removes that word without executing it and pulses a request to clear the loop counter. This stops a repeating group, or a standing repeated solo word, at a known point. Datapath execution, predicate evaluation and the loop counter arithmetic all belong to neighbouring logic. The block receives only a predicate-true flag, an execution-ready flag and a loop-count-nonzero flag.

Top module: `reloop_queue`

## Requirements
- R1: After reset the queue is empty (`q_count` = 0), nothing is on deck, `grp_lock`, `kill_waiting`, `exec_fire` and `lc_clear` are low, and `in_ready` is high for an ordinary word.
- R2: Word fields are as follows. Bits 36:35 are the grouping code: 00 solo, 01 killable solo, 10 group body, 11 group tail. Bits 34:33 are the predicate. Bits 10:0 are the dispatch path. A word whose bits 32:30 equal 3'b111 is a kill instruction, whatever its other bits.
- R3: Solo words (codes 00 and 01) execute exactly once each, in arrival order, whatever the value of `loop_nz`.
- R4: A body or tail word that arrives on deck while `loop_nz` is 0 is discarded without `exec_fire`.
- R5: A body or tail word that arrives on deck while `loop_nz` is 1 places a copy of itself at the back of the queue in its arrival cycle. The original stays on deck, unchanged, until `exec_ok` is high. A group of G words with a loop count of N therefore executes each word N times, in group order.
- R6: Once a tail word has been accepted, non-kill words see `in_ready` low until no body or tail word remains in the queue or on deck. `grp_lock` is high for exactly that span.
- R7: A kill word is accepted whenever no kill is waiting, even while `grp_lock` is high. It waits (`kill_waiting` high) until the on-deck word has code 11 or 01. It then removes that word without `exec_fire` and pulses `lc_clear` for one cycle.
- R8: Body (10) and plain solo (00) words are immune to a waiting kill. They execute normally, and the kill keeps waiting.
- R9: An on-deck word with `pred_ok` low retires when `exec_ok` is high, without `exec_fire`. Its copy is still made as in R5.
- R10: Ordinary words are accepted only while `q_count` < DEPTH-1. Copies take priority over external words, so a copy always finds a free slot.
- R11: `exec_fire` is high only in a cycle where a word is on deck and both `exec_ok` and `pred_ok` are high. It stays low while `exec_ok` is low.
- R12: A body or tail word leaves the queue for the on-deck register only after the tail of its group has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming word is valid |
| in_word | input | 37 | Incoming micro-instruction word |
| in_ready | output | 1 | Incoming word is accepted this cycle if valid |
| exec_ok | input | 1 | Execution conditions for the on-deck word are met |
| pred_ok | input | 1 | Predicate of the on-deck word evaluated true |
| loop_nz | input | 1 | Shared loop counter is nonzero |
| od_valid | output | 1 | A word is on deck |
| od_word | output | 37 | The on-deck word |
| exec_fire | output | 1 | The on-deck word executes this cycle |
| lc_clear | output | 1 | Request to force the loop counter to zero |
| q_count | output | $clog2(DEPTH+1) | Number of words in the queue, excluding on deck |
| grp_lock | output | 1 | External non-kill input is locked out by a group |
| kill_waiting | output | 1 | A kill instruction is held and waiting |

## Verification
The hardest situation to reach from the ports is a kill that lands on a tail word while copies of earlier group words are already queued behind it. The stimulus gets there by holding `exec_ok` low after a two-word group is enqueued with a large loop count. It then sends the kill while the body word sits on deck, so the kill must wait, and finally releases `exec_ok`. The remaining copies must then die because the loop count was cleared. A queue-capacity case, which fills the queue with `exec_ok` low, shows the reserved slot. Groups of one to three words at loop counts 0, 1 and 3 are checked against a per-word repeat model.

// File: rtl/reloop_pkg.sv
package reloop_pkg;
  localparam int WORD_W = 37;
  localparam int GRP_MSB = 36;
  localparam int OP_MSB = 32;
  localparam logic [2:0] OP_KILL = 3'b111;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    GRP_SOLO   = 2'b00,
    GRP_SOLO_K = 2'b01,
    GRP_BODY   = 2'b10,
    GRP_TAIL   = 2'b11
  } grp_e;

  function automatic grp_e grp_of(input word_t w);
    return grp_e'(w[GRP_MSB -: 2]);
  endfunction

  // body or tail: takes part in relooping
  function automatic logic is_grouped(input word_t w);
    return grp_of(w) == GRP_BODY || grp_of(w) == GRP_TAIL;
  endfunction

  // tail or killable solo: target of a waiting kill
  function automatic logic is_killable(input word_t w);
    return grp_of(w) == GRP_TAIL || grp_of(w) == GRP_SOLO_K;
  endfunction

  function automatic logic is_kill(input word_t w);
    return w[OP_MSB -: 3] == OP_KILL;
  endfunction
endpackage

// File: rtl/reloop_fifo.sv
module reloop_fifo
  import reloop_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  word_t         push_word,
  input  logic          pop,
  output word_t         head_word,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  word_t mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] wr_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  assign head_word = mem[rd_ptr];

  // R10: storage never overflows or underflows
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CW'(DEPTH)));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/reloop_deck.sv
module reloop_deck
  import reloop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  head_avail,
  input  word_t head_word,
  input  logic  grp_lock,
  input  logic  exec_ok,
  input  logic  pred_ok,
  input  logic  loop_nz,
  input  logic  kill_pend,
  output logic  od_valid,
  output word_t od_word,
  output logic  pop,
  output logic  dup_push,
  output logic  exec_fire,
  output logic  kill_now,
  output logic  grp_leave
);
  logic od_new;
  logic die_now;
  logic go_now;
  logic od_leave;
  logic head_free;

  always_comb begin
    kill_now  = kill_pend && od_valid && is_killable(od_word);
    die_now   = od_valid && od_new && is_grouped(od_word) && !loop_nz && !kill_now;
    dup_push  = od_valid && od_new && is_grouped(od_word) && loop_nz && !kill_now;
    go_now    = od_valid && !kill_now && !die_now && exec_ok;
    exec_fire = go_now && pred_ok;
    od_leave  = kill_now || die_now || go_now;
    grp_leave = od_leave && is_grouped(od_word);
    // a group word waits in the queue until its tail is in
    head_free = !is_grouped(head_word) || grp_lock;
    pop       = head_avail && head_free && (!od_valid || od_leave);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_valid <= 1'b0;
      od_new   <= 1'b0;
      od_word  <= '0;
    end else if (pop) begin
      od_valid <= 1'b1;
      od_new   <= 1'b1;
      od_word  <= head_word;
    end else begin
      od_new <= 1'b0;
      if (od_leave) od_valid <= 1'b0;
    end
  end

  // R5: a waiting on-deck word stays put and unchanged
  a_r5_deck_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(od_valid) && !$past(od_leave)) |-> (od_valid && $stable(od_word) && !od_new));
  // R12: a group word reaches deck only after the group lock was raised
  a_r12_grp_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (od_new && is_grouped(od_word)) |-> $past(grp_lock));
endmodule

// File: rtl/reloop_admit.sv
module reloop_admit
  import reloop_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  word_t         in_word,
  input  logic          dup_push,
  input  word_t         dup_word,
  input  logic [CW-1:0] q_count,
  input  logic          kill_now,
  input  logic          grp_leave,
  output logic          in_ready,
  output logic          fifo_push,
  output word_t         fifo_word,
  output logic          kill_pend,
  output logic          grp_lock
);
  localparam int GW = CW + 1;

  logic [GW-1:0] grp_cnt;
  logic [GW-1:0] grp_cnt_nxt;
  logic          lock_nxt;
  logic          word_kill;
  logic          space_ok;
  logic          take;
  logic          take_kill;
  logic          take_norm;

  function automatic logic [GW-1:0] grp_step(input logic [GW-1:0] c, input logic add_ext,
                                              input logic add_dup, input logic sub_leave);
    return c + GW'(add_ext) + GW'(add_dup) - GW'(sub_leave);
  endfunction

  always_comb begin
    word_kill   = is_kill(in_word);
    space_ok    = q_count < CW'(DEPTH - 1);
    in_ready    = word_kill ? !kill_pend : (!dup_push && !grp_lock && space_ok);
    take        = in_valid && in_ready;
    take_kill   = take && word_kill;
    take_norm   = take && !word_kill;
    fifo_push   = dup_push || take_norm;
    fifo_word   = dup_push ? dup_word : in_word;
    grp_cnt_nxt = grp_step(grp_cnt, take_norm && is_grouped(in_word), dup_push, grp_leave);
    lock_nxt    = (grp_lock || (take_norm && grp_of(in_word) == GRP_TAIL)) && (grp_cnt_nxt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_cnt   <= '0;
      grp_lock  <= 1'b0;
      kill_pend <= 1'b0;
    end else begin
      grp_cnt  <= grp_cnt_nxt;
      grp_lock <= lock_nxt;
      if (take_kill)     kill_pend <= 1'b1;
      else if (kill_now) kill_pend <= 1'b0;
    end
  end

  // R6: the lock only drops once no group word is left
  a_r6_lock_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grp_lock) |-> (grp_cnt == '0));
  // R7: a waiting kill leaves only by striking
  a_r7_kill_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_pend && !kill_now) |=> kill_pend);
endmodule

// File: rtl/reloop_queue.sv
module reloop_queue
  import reloop_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [36:0]   in_word,
  output logic          in_ready,
  input  logic          exec_ok,
  input  logic          pred_ok,
  input  logic          loop_nz,
  output logic          od_valid,
  output logic [36:0]   od_word,
  output logic          exec_fire,
  output logic          lc_clear,
  output logic [CW-1:0] q_count,
  output logic          grp_lock,
  output logic          kill_waiting
);
  logic  fifo_push;
  logic  fifo_pop;
  word_t fifo_word;
  word_t head_word;
  logic  dup_push;
  logic  kill_now;
  logic  grp_leave;
  logic  kill_pend;

  reloop_admit #(.DEPTH(DEPTH), .CW(CW)) admit_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .dup_push(dup_push), .dup_word(od_word), .q_count(q_count),
    .kill_now(kill_now), .grp_leave(grp_leave), .in_ready(in_ready),
    .fifo_push(fifo_push), .fifo_word(fifo_word), .kill_pend(kill_pend),
    .grp_lock(grp_lock)
  );

  reloop_fifo #(.DEPTH(DEPTH), .CW(CW)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_word(fifo_word),
    .pop(fifo_pop), .head_word(head_word), .count(q_count)
  );

  reloop_deck deck_i (
    .clk(clk), .rst_n(rst_n), .head_avail(q_count != '0), .head_word(head_word),
    .grp_lock(grp_lock), .exec_ok(exec_ok), .pred_ok(pred_ok), .loop_nz(loop_nz),
    .kill_pend(kill_pend), .od_valid(od_valid), .od_word(od_word), .pop(fifo_pop),
    .dup_push(dup_push), .exec_fire(exec_fire), .kill_now(kill_now),
    .grp_leave(grp_leave)
  );

  assign lc_clear     = kill_now;
  assign kill_waiting = kill_pend;

  // R10: a copy always lands in a free slot
  a_r10_copy_fits: assert property (@(posedge clk) disable iff (!rst_n)
    dup_push |-> (q_count < CW'(DEPTH)));
  // R7: the clear request is a single-cycle pulse
  a_r7_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lc_clear |=> !lc_clear);
endmodule

// File: tb/reloop_queue_tb.sv
module reloop_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [36:0] in_word;
  logic in_ready;
  logic exec_ok;
  logic pred_ok;
  logic loop_nz;
  logic od_valid;
  logic [36:0] od_word;
  logic exec_fire;
  logic lc_clear;
  logic [CW-1:0] q_count;
  logic grp_lock;
  logic kill_waiting;

  int checks = 0;
  int fails = 0;
  int fires = 0;
  int clears = 0;
  int lc = 0;
  int cyc = 0;
  string cur_req = "R1";
  logic [36:0] exp_q[$];

  always #5 clk = ~clk;

  reloop_queue #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .exec_ok(exec_ok), .pred_ok(pred_ok), .loop_nz(loop_nz),
    .od_valid(od_valid), .od_word(od_word), .exec_fire(exec_fire),
    .lc_clear(lc_clear), .q_count(q_count), .grp_lock(grp_lock),
    .kill_waiting(kill_waiting)
  );

  // bench convention: predicate code 01 means "never"
  assign pred_ok = (od_word[34:33] != 2'b01);
  assign loop_nz = (lc != 0);

  function automatic logic [36:0] mk(input logic [1:0] grp, input logic [1:0] pred,
                                     input logic [2:0] op, input int tag);
    return {grp, pred, op, 19'(tag), 11'(tag * 7 + 3)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // scoreboard monitor and loop counter model (tail execution decrements)
  always @(negedge clk) begin
    if (rst_n) begin
      if (exec_fire) begin
        fires++;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected execute actual=%0h expected=none", cur_req, od_word);
        end else begin
          logic [36:0] e;
          e = exp_q.pop_front();
          if (e !== od_word) begin
            fails++;
            $display("FAIL %s execute order actual=%0h expected=%0h", cur_req, od_word, e);
          end
        end
        if (od_word[36:35] == 2'b11 && lc > 0) lc--;
      end
      if (lc_clear) begin
        clears++;
        lc = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic push(input logic [36:0] w);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1;
    in_word = w;
    forever begin
      #3 acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic set_ok(input logic v);
    @(posedge clk);
    #1 exec_ok = v;
  endtask

  task automatic drain();
    int n = 0;
    while (!(q_count == 0 && !od_valid && !grp_lock) && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  initial begin
    int f0;
    int c0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    exec_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(od_valid == 0, "R1 od_valid", od_valid, 0);
    chk(q_count == 0, "R1 q_count", q_count, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(exec_fire == 0 && lc_clear == 0, "R1 strobes", {exec_fire, lc_clear}, 0);
    chk(grp_lock == 0 && kill_waiting == 0, "R1 flags", {grp_lock, kill_waiting}, 0);

    // R3 solo words ignore the loop counter
    cur_req = "R3";
    lc = 3;
    set_ok(1'b1);
    f0 = fires;
    for (int i = 0; i < 3; i++) exp_q.push_back(mk((i == 1) ? 2'b01 : 2'b00, 2'b00, 3'b000, 100 + i));
    for (int i = 0; i < 3; i++) push(mk((i == 1) ? 2'b01 : 2'b00, 2'b00, 3'b000, 100 + i));
    drain();
    chk(fires - f0 == 3, "R3 solo count", fires - f0, 3);
    chk(lc == 3, "R3 counter untouched", lc, 3);

    // R4/R5 reloop model: each group word runs N times (R2 grouping codes)
    for (int g = 1; g <= 3; g++) begin
      for (int k = 0; k < 3; k++) begin
        int nv;
        nv = (k == 0) ? 0 : ((k == 1) ? 1 : 3);
        cur_req = (nv == 0) ? "R4" : "R5";
        lc = nv;
        f0 = fires;
        for (int n = 0; n < nv; n++)
          for (int i = 0; i < g; i++)
            exp_q.push_back(mk((i == g - 1) ? 2'b11 : 2'b10, 2'b00, 3'b000, 200 + g * 16 + k * 4 + i));
        for (int i = 0; i < g; i++)
          push(mk((i == g - 1) ? 2'b11 : 2'b10, 2'b00, 3'b000, 200 + g * 16 + k * 4 + i));
        drain();
        chk(fires - f0 == g * nv, cur_req, fires - f0, g * nv);
        chk(lc == 0, cur_req, lc, 0);
      end
    end

    // R12 body waits in the queue until its tail arrives
    cur_req = "R12";
    lc = 1;
    push(mk(2'b10, 2'b00, 3'b000, 300));
    repeat (5) @(negedge clk);
    chk(od_valid == 0, "R12 body not on deck", od_valid, 0);
    chk(q_count == 1, "R12 body queued", q_count, 1);
    exp_q.push_back(mk(2'b10, 2'b00, 3'b000, 300));
    exp_q.push_back(mk(2'b11, 2'b00, 3'b000, 301));
    push(mk(2'b11, 2'b00, 3'b000, 301));
    drain();

    // R5/R6 copy while holding, lock refuses ordinary input
    cur_req = "R6";
    set_ok(1'b0);
    lc = 2;
    f0 = fires;
    push(mk(2'b10, 2'b00, 3'b000, 400));
    push(mk(2'b11, 2'b00, 3'b000, 401));
    repeat (4) @(negedge clk);
    chk(grp_lock == 1, "R6 lock raised", grp_lock, 1);
    chk(q_count == 2, "R5 copy queued", q_count, 2);
    chk(od_word == mk(2'b10, 2'b00, 3'b000, 400), "R5 body on deck", od_word, mk(2'b10, 2'b00, 3'b000, 400));
    @(negedge clk);
    in_valid = 1'b1;
    in_word = mk(2'b00, 2'b00, 3'b000, 402);
    #3 chk(in_ready == 0, "R6 in_ready low", in_ready, 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(q_count == 2, "R6 nothing accepted", q_count, 2);
    chk(fires - f0 == 0, "R11 no fire without exec_ok", fires - f0, 0);
    for (int n = 0; n < 2; n++) begin
      exp_q.push_back(mk(2'b10, 2'b00, 3'b000, 400));
      exp_q.push_back(mk(2'b11, 2'b00, 3'b000, 401));
    end
    set_ok(1'b1);
    drain();
    chk(fires - f0 == 4, "R5 repeats", fires - f0, 4);
    chk(grp_lock == 0, "R6 lock released", grp_lock, 0);
    chk(in_ready == 1, "R6 ready again", in_ready, 1);

    // R7/R8 kill waits past a body word, then strikes the tail
    cur_req = "R7";
    set_ok(1'b0);
    lc = 5;
    f0 = fires;
    c0 = clears;
    push(mk(2'b10, 2'b00, 3'b000, 500));
    push(mk(2'b11, 2'b00, 3'b000, 501));
    repeat (3) @(negedge clk);
    push(mk(2'b00, 2'b00, 3'b111, 502));
    @(negedge clk);
    chk(kill_waiting == 1, "R2 kill word recognised under lock", kill_waiting, 1);
    repeat (4) @(negedge clk);
    chk(kill_waiting == 1, "R8 body immune", kill_waiting, 1);
    chk(clears - c0 == 0, "R8 no clear on body", clears - c0, 0);
    exp_q.push_back(mk(2'b10, 2'b00, 3'b000, 500));
    set_ok(1'b1);
    drain();
    chk(fires - f0 == 1, "R7 killed group fires", fires - f0, 1);
    chk(clears - c0 == 1, "R7 one clear pulse", clears - c0, 1);
    chk(lc == 0, "R7 counter cleared", lc, 0);
    chk(kill_waiting == 0, "R7 kill retired", kill_waiting, 0);

    // R8 plain solo immune, killable solo struck
    cur_req = "R8";
    set_ok(1'b0);
    lc = 4;
    f0 = fires;
    c0 = clears;
    push(mk(2'b00, 2'b00, 3'b000, 600));
    push(mk(2'b01, 2'b00, 3'b000, 601));
    push(mk(2'b00, 2'b00, 3'b111, 602));
    repeat (4) @(negedge clk);
    chk(kill_waiting == 1, "R8 solo immune", kill_waiting, 1);
    exp_q.push_back(mk(2'b00, 2'b00, 3'b000, 600));
    set_ok(1'b1);
    drain();
    chk(fires - f0 == 1, "R7 killable solo removed", fires - f0, 1);
    chk(clears - c0 == 1 && lc == 0, "R7 solo kill clears", lc, 0);

    // R9 false predicate retires silently, copies still made
    cur_req = "R9";
    lc = 2;
    f0 = fires;
    exp_q.push_back(mk(2'b11, 2'b00, 3'b000, 701));
    exp_q.push_back(mk(2'b11, 2'b00, 3'b000, 701));
    push(mk(2'b10, 2'b01, 3'b000, 700));
    push(mk(2'b11, 2'b00, 3'b000, 701));
    drain();
    chk(fires - f0 == 2, "R9 only tail fires", fires - f0, 2);
    chk(lc == 0, "R9 loop finished", lc, 0);

    // R10 capacity with one slot reserved, R11 no fire while held
    cur_req = "R10";
    set_ok(1'b0);
    lc = 0;
    f0 = fires;
    begin
      int acc_n = 0;
      for (int i = 0; i < DEPTH + 3; i++) begin
        bit acc;
        @(negedge clk);
        in_valid = 1'b1;
        in_word = mk(2'b00, 2'b00, 3'b000, 800 + acc_n);
        #3 acc = in_ready;
        @(posedge clk);
        if (acc) acc_n++;
      end
      #1 in_valid = 1'b0;
      chk(acc_n == DEPTH, "R10 accepted words", acc_n, DEPTH);
      @(negedge clk);
      chk(q_count == DEPTH - 1, "R10 queue level", q_count, DEPTH - 1);
      in_word = mk(2'b00, 2'b00, 3'b000, 899);
      #1 chk(in_ready == 0, "R10 ready low", in_ready, 0);
      chk(fires - f0 == 0, "R11 held deck silent", fires - f0, 0);
      for (int i = 0; i < acc_n; i++) exp_q.push_back(mk(2'b00, 2'b00, 3'b000, 800 + i));
    end
    set_ok(1'b1);
    drain();
    chk(fires - f0 == DEPTH, "R10 all drained", fires - f0, DEPTH);

    summary();
  end
endmodule